// File: doc/BRIEF.md
# Cascadable Dual Phase Counter

The block decodes external two-phase position signals (quadrature encoders or step/direction sources) into counts. It holds two 16-bit counting channels. Each channel follows one pin pair and uses one of three counting functions. Each channel wraps against its own programmable ceiling. A shared control bit joins the two channels into one 32-bit counter with its own 32-bit ceiling. A second shared bit moves channel 1 from pin pair A/B to pin pair C/D. All four pins pass through a two-flop synchronizer before any edge is detected.

Software uses a plain synchronous register port. A write lands on the rising clock edge where `reg_wr` is high. Read data is combinational from `reg_addr` while `reg_rd` is high. An access that the current width mode does not allow raises `reg_busy` in the same cycle. Such a write is dropped, and such a read returns zero. The port has no data stream and no back-pressure, so there is no valid/ready handshake.

Channel 0 always counts from A/B. While the block is cascaded, the 32-bit counter also counts from A/B and uses channel 0's function and enable. The low half of the 32-bit counter is channel 0's count and the high half is channel 1's count.

Top module: `dual_phase_counter`

## Requirements
- R1: Register addresses are fixed as follows:
  - 0: control. Bit 0 is cascade and bit 1 is the channel-1 pin select.
  - 1 and 2: mode of channel 0 and channel 1. Bits 3:0 are the function code and bit 4 is enable.
  - 3 and 4: 16-bit count of each channel.
  - 5 and 6: 16-bit ceiling of each channel.
  - 7 and 8: status of each channel.
  - 9: 32-bit count.
  - 10: 32-bit ceiling.
- R1 (reset values): control reads 0, mode reads 0x04 (x4 function, disabled), counts read 0, status reads 0, the 16-bit ceilings read 0xFFFF and the 32-bit ceiling reads 0xFFFFFFFF.
- R2: With function code 4 (x4), every single transition of A or of B changes the count by one. A leading B counts up, and B leading A counts down. Concretely, after an A edge the count goes up when A differs from B. After a B edge the count goes up when A equals B.
- R3: With function code 5 (pulse/direction), only a rising edge of A changes the count. The count goes up when B is high and down when B is low. Falling A edges and all B edges leave the count unchanged.
- R4: With function code 7 (x2 on B), only edges of B change the count. The count goes up when A equals B after the edge and down otherwise. A edges leave the count unchanged.
- R5: With any other function code, no pin activity changes the count.
- R6: Status bit 7 reads 1 after the most recent applied count went up and 0 after it went down.
- R7: Counting up from a value equal to the ceiling gives 0. Counting down from 0 gives the ceiling value.
- R8: While the enable bit (mode bit 4) is 0, pin activity leaves the count unchanged.
- R9: With control bit 0 set, the two channels form one 32-bit counter at address 9. A carry from the low half propagates into the high half, and the counter wraps against the 32-bit ceiling at address 10.
- R10: While cascaded, accesses to addresses 3 to 6 raise `reg_busy`, a write there is dropped and a read returns 0. While not cascaded, addresses 9 and 10 are treated the same way.
- R11: With control bit 1 set, channel 1 counts from C (as its A) and D (as its B), and A/B no longer affect it. Channel 0 keeps counting from A/B.
- R12: A software write to a count register takes effect over a count event that lands on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | Phase input A (asynchronous) |
| pin_b | input | 1 | Phase input B (asynchronous) |
| pin_c | input | 1 | Alternate phase input C for channel 1 |
| pin_d | input | 1 | Alternate phase input D for channel 1 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading or rejected |
| reg_busy | output | 1 | Access rejected in the current width mode |

## Verification
The hardest case to reach is the collision in R12: a software count write that lands on the exact clock edge where a synchronized pin edge applies. The pin edge reaches the counter three clock edges after the pin changes, through two synchronizer flops and the edge-detect register. The stimulus therefore changes pin A at a falling clock edge and waits two more falling edges. It then holds the write strobe across the third rising edge, so the event and the write meet on that edge. The cascade carry and wrap tests preload values next to the 16-bit and ceiling boundaries through the 32-bit count register, so that a single pin edge crosses the boundary.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // register addresses
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_MODE0 = 4'd1;
  localparam logic [3:0] A_CNT0  = 4'd3;
  localparam logic [3:0] A_CEIL0 = 4'd5;
  localparam logic [3:0] A_STAT0 = 4'd7;
  localparam logic [3:0] A_LCNT  = 4'd9;
  localparam logic [3:0] A_LCEIL = 4'd10;

  // counting function codes
  localparam logic [3:0] FN_X4  = 4'd4;
  localparam logic [3:0] FN_PD  = 4'd5;
  localparam logic [3:0] FN_X2B = 4'd7;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dpc_decode.sv
module dpc_decode
  import dpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph_a,
  input  logic       ph_b,
  input  logic [3:0] fn,
  output step_t      ev
);
  logic pa_q, pb_q;
  logic ea, eb, same;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= ph_a;
      pb_q <= ph_b;
    end
  end

  assign ea   = ph_a ^ pa_q;
  assign eb   = ph_b ^ pb_q;
  assign same = ~(ph_a ^ ph_b);

  always_comb begin
    ev = '0;
    case (fn)
      FN_X4: begin
        if (ea && !eb) begin
          ev.up = ~same;
          ev.dn = same;
        end else if (eb && !ea) begin
          ev.up = same;
          ev.dn = ~same;
        end
      end
      FN_PD: begin
        if (ea && ph_a) begin
          ev.up = ph_b;
          ev.dn = ~ph_b;
        end
      end
      FN_X2B: begin
        if (eb) begin
          ev.up = same;
          ev.dn = ~same;
        end
      end
      default: ev = '0;
    endcase
  end
endmodule

// File: rtl/dpc_step.sv
module dpc_step
  import dpc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] ceil,
  input  step_t        ev,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (load)        nxt = load_val;
    else if (ev.up)  nxt = (cur == ceil) ? '0 : cur + W'(1);
    else if (ev.dn)  nxt = (cur == '0) ? ceil : cur - W'(1);
  end
endmodule

// File: rtl/dual_phase_counter.sv
module dual_phase_counter
  import dpc_pkg::*;
#(
  parameter int CW = 16,
  localparam int DW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic          pin_c,
  input  logic          pin_d,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_busy
);
  localparam int NCH = 2;

  logic [3:0] pins_s;
  logic       casc_q, psel_q;
  logic [DW-1:0] lceil_q, lnxt, rmux;
  logic [NCH-1:0] ph_a, ph_b;
  logic [NCH-1:0][CW-1:0] cnt_all, ceil_all;
  logic [NCH-1:0][3:0] fn_all;
  logic [NCH-1:0] en_all, dir_all;
  step_t [NCH-1:0] evg_all;
  logic narrow_adr, wide_adr, wr_ok;

  dpc_sync #(.N(4), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pin_d, pin_c, pin_b, pin_a}), .q(pins_s)
  );

  assign ph_a[0] = pins_s[0];
  assign ph_b[0] = pins_s[1];
  assign ph_a[1] = psel_q ? pins_s[2] : pins_s[0];
  assign ph_b[1] = psel_q ? pins_s[3] : pins_s[1];

  // access legality
  assign narrow_adr = (reg_addr >= A_CNT0) && (reg_addr <= A_CEIL0 + 4'd1);
  assign wide_adr   = (reg_addr == A_LCNT) || (reg_addr == A_LCEIL);
  assign reg_busy   = (reg_rd || reg_wr) && (casc_q ? narrow_adr : wide_adr);
  assign wr_ok      = reg_wr && !reg_busy;

  // cascaded 32-bit step over both count registers
  dpc_step #(.W(DW)) u_lstep (
    .cur(cnt_all), .ceil(lceil_q), .ev(evg_all[0]),
    .load(wr_ok && (reg_addr == A_LCNT)), .load_val(reg_wdata), .nxt(lnxt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [3:0] AD_MODE = A_MODE0 + 4'(i);
    localparam logic [3:0] AD_CNT  = A_CNT0  + 4'(i);
    localparam logic [3:0] AD_CEIL = A_CEIL0 + 4'(i);

    logic [CW-1:0] cnt_q, ceil_q, nxt;
    logic [3:0]    fn_q;
    logic          en_q, dir_q;
    step_t         ev, evg;

    dpc_decode u_dec (
      .clk(clk), .rst_n(rst_n), .ph_a(ph_a[i]), .ph_b(ph_b[i]),
      .fn(fn_q), .ev(ev)
    );

    assign evg = en_q ? ev : '0;

    dpc_step #(.W(CW)) u_step (
      .cur(cnt_q), .ceil(ceil_q), .ev(evg),
      .load(wr_ok && (reg_addr == AD_CNT)),
      .load_val(reg_wdata[CW-1:0]), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        ceil_q <= '1;
        fn_q   <= FN_X4;
        en_q   <= 1'b0;
        dir_q  <= 1'b0;
      end else begin
        if (wr_ok && (reg_addr == AD_MODE)) begin
          fn_q <= reg_wdata[3:0];
          en_q <= reg_wdata[4];
        end
        if (wr_ok && (reg_addr == AD_CEIL)) ceil_q <= reg_wdata[CW-1:0];
        if (casc_q) begin
          cnt_q <= lnxt[i*CW +: CW];
          if ((i == 0) && (evg.up || evg.dn)) dir_q <= evg.up;
        end else begin
          cnt_q <= nxt;
          if (evg.up || evg.dn) dir_q <= evg.up;
        end
      end
    end

    assign cnt_all[i]  = cnt_q;
    assign ceil_all[i] = ceil_q;
    assign fn_all[i]   = fn_q;
    assign en_all[i]   = en_q;
    assign dir_all[i]  = dir_q;
    assign evg_all[i]  = evg;
  end

  // shared control and 32-bit ceiling
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      casc_q  <= 1'b0;
      psel_q  <= 1'b0;
      lceil_q <= '1;
    end else begin
      if (wr_ok && (reg_addr == A_CTRL)) begin
        casc_q <= reg_wdata[0];
        psel_q <= reg_wdata[1];
      end
      if (wr_ok && (reg_addr == A_LCEIL)) lceil_q <= reg_wdata;
    end
  end

  always_comb begin
    rmux = '0;
    case (reg_addr)
      A_CTRL:        rmux = DW'({psel_q, casc_q});
      A_MODE0:       rmux = DW'({en_all[0], fn_all[0]});
      A_MODE0 + 4'd1: rmux = DW'({en_all[1], fn_all[1]});
      A_CNT0:        rmux = DW'(cnt_all[0]);
      A_CNT0 + 4'd1: rmux = DW'(cnt_all[1]);
      A_CEIL0:       rmux = DW'(ceil_all[0]);
      A_CEIL0 + 4'd1: rmux = DW'(ceil_all[1]);
      A_STAT0:       rmux = DW'({dir_all[0], 7'b0});
      A_STAT0 + 4'd1: rmux = DW'({dir_all[1], 7'b0});
      A_LCNT:        rmux = cnt_all;
      A_LCEIL:       rmux = lceil_q;
      default:       rmux = '0;
    endcase
  end

  assign reg_rdata = (reg_rd && !reg_busy) ? rmux : '0;
endmodule

// File: rtl/dpc_chk.sv
module dpc_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic          reg_busy,
  input logic          casc,
  input logic          en0,
  input logic [3:0]    fn0,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] ceil0,
  input logic          dir0
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  AST_BUSY_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_busy |-> (reg_rd || reg_wr)); // R10

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !reg_wr) |=> $stable(cnt0)); // R8

  AST_UNSUPPORTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((fn0 != 4'd4) && (fn0 != 4'd5) && (fn0 != 4'd7) && !reg_wr) |=> $stable(cnt0)); // R5

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc && !reg_wr) |=> ((cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + ONE) ||
                            (cnt0 == $past(cnt0) - ONE) || (cnt0 == '0) ||
                            (cnt0 == $past(ceil0)))); // R7

  AST_UP_SETS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc && !reg_wr && en0) ##1 ((cnt0 == $past(cnt0) + ONE) && ($past(cnt0) != '0))
    |-> dir0); // R6
endmodule

bind dual_phase_counter dpc_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_busy(reg_busy),
  .casc(casc_q), .en0(en_all[0]), .fn0(fn_all[0]), .cnt0(cnt_all[0]),
  .ceil0(ceil_all[0]), .dir0(dir_all[0])
);

// File: tb/dual_phase_counter_tb.sv
module dual_phase_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 0, pin_b = 0, pin_c = 0, pin_d = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_busy;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_phase_counter dut_i (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
    .pin_d(pin_d), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_busy(reg_busy)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    chk(tag, d, exp);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic expect_busy(input string tag, input logic [3:0] a, input bit is_wr,
                             input logic [31:0] d);
    reg_addr = a; reg_wdata = d;
    if (is_wr) reg_wr = 1'b1; else reg_rd = 1'b1;
    #1 chk(tag, {31'b0, reg_busy}, 32'd1);
    if (!is_wr) chk({tag, " data"}, reg_rdata, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic step(input logic a, input logic b, input logic c, input logic d);
    pin_a = a; pin_b = b; pin_c = c; pin_d = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1 ctrl", 4'd0, 32'h0);
    expect_reg("R1 mode0", 4'd1, 32'h04);
    expect_reg("R1 mode1", 4'd2, 32'h04);
    expect_reg("R1 cnt0", 4'd3, 32'h0);
    expect_reg("R1 ceil0", 4'd5, 32'hFFFF);
    expect_reg("R1 ceil1", 4'd6, 32'hFFFF);
    expect_reg("R1 stat0", 4'd7, 32'h0);
  endtask

  task automatic t_x4;
    wr_reg(4'd1, 32'h14);
    step(1,0,0,0); step(1,1,0,0); step(0,1,0,0); step(0,0,0,0);
    expect_reg("R2 x4 A leads", 4'd3, 32'd4);
    expect_reg("R6 dir up", 4'd7, 32'h80);
    step(0,1,0,0); step(1,1,0,0); step(1,0,0,0); step(0,0,0,0);
    expect_reg("R2 x4 B leads", 4'd3, 32'd0);
    expect_reg("R6 dir down", 4'd7, 32'h00);
    step(0,1,0,0);
    expect_reg("R7 down from 0 to max", 4'd3, 32'hFFFF);
    step(0,0,0,0);
    expect_reg("R7 up from max to 0", 4'd3, 32'd0);
  endtask

  task automatic t_ceiling;
    wr_reg(4'd5, 32'd5);
    wr_reg(4'd3, 32'd5);
    step(1,0,0,0);
    expect_reg("R7 up at ceiling", 4'd3, 32'd0);
    step(0,0,0,0);
    expect_reg("R7 down to ceiling", 4'd3, 32'd5);
  endtask

  task automatic t_pd;
    wr_reg(4'd1, 32'h15);
    wr_reg(4'd3, 32'd0);
    step(0,1,0,0);
    expect_reg("R3 B edge ignored", 4'd3, 32'd0);
    step(1,1,0,0);
    expect_reg("R3 A rise B high up", 4'd3, 32'd1);
    step(0,1,0,0); step(0,0,0,0);
    expect_reg("R3 A fall and B fall ignored", 4'd3, 32'd1);
    step(1,0,0,0);
    expect_reg("R3 A rise B low down", 4'd3, 32'd0);
    step(0,0,0,0);
  endtask

  task automatic t_x2b;
    wr_reg(4'd1, 32'h17);
    wr_reg(4'd3, 32'd2);
    step(1,0,0,0);
    expect_reg("R4 A edge ignored", 4'd3, 32'd2);
    step(1,1,0,0);
    expect_reg("R4 B rise A high up", 4'd3, 32'd3);
    step(1,0,0,0); step(0,0,0,0);
    expect_reg("R4 B fall down, A fall ignored", 4'd3, 32'd2);
    step(0,1,0,0);
    expect_reg("R4 B rise A low down", 4'd3, 32'd1);
    step(0,0,0,0);
    expect_reg("R4 B fall A low up", 4'd3, 32'd2);
  endtask

  task automatic t_unsupported;
    wr_reg(4'd1, 32'h16);
    wr_reg(4'd3, 32'd7);
    step(1,0,0,0); step(1,1,0,0); step(0,1,0,0); step(0,0,0,0);
    expect_reg("R5 code 6 no count", 4'd3, 32'd7);
  endtask

  task automatic t_disabled;
    wr_reg(4'd1, 32'h04);
    step(1,0,0,0); step(1,1,0,0); step(0,1,0,0); step(0,0,0,0);
    expect_reg("R8 disabled no count", 4'd3, 32'd7);
  endtask

  task automatic t_collide;
    wr_reg(4'd1, 32'h14);
    wr_reg(4'd3, 32'd0);
    pin_a = 1'b1;
    repeat (2) @(negedge clk);
    wr_reg(4'd3, 32'h1234);
    expect_reg("R12 write beats event", 4'd3, 32'h1234);
    step(0,0,0,0);
    expect_reg("R2 A fall B low down", 4'd3, 32'h1233);
  endtask

  task automatic t_pinsel;
    wr_reg(4'd1, 32'h00);
    wr_reg(4'd2, 32'h14);
    wr_reg(4'd4, 32'd0);
    step(0,0,1,0);
    expect_reg("R11 C ignored when unselected", 4'd4, 32'd0);
    step(1,0,1,0);
    expect_reg("R11 ch1 on A/B", 4'd4, 32'd1);
    wr_reg(4'd0, 32'h2);
    step(0,0,1,0);
    expect_reg("R11 A ignored when C/D selected", 4'd4, 32'd1);
    step(0,0,1,1);
    expect_reg("R11 ch1 on D edge", 4'd4, 32'd2);
    wr_reg(4'd1, 32'h14);
    wr_reg(4'd3, 32'd0);
    step(1,0,1,1);
    expect_reg("R11 ch0 stays on A/B", 4'd3, 32'd1);
    expect_reg("R11 ch1 not moved by A", 4'd4, 32'd2);
    wr_reg(4'd2, 32'h00);
    wr_reg(4'd0, 32'h0);
    step(0,0,0,0);
  endtask

  task automatic t_cascade;
    expect_busy("R10 lcnt busy in 16-bit", 4'd9, 1'b0, 32'h0);
    wr_reg(4'd0, 32'h1);
    expect_busy("R10 cnt0 read busy", 4'd3, 1'b0, 32'h0);
    expect_busy("R10 ceil0 read busy", 4'd5, 1'b0, 32'h0);
    expect_busy("R10 cnt1 write busy", 4'd4, 1'b1, 32'h55);
    expect_reg("R10 dropped write", 4'd9, 32'h0002_0000);
    expect_reg("R1 long ceiling", 4'd10, 32'hFFFF_FFFF);
    wr_reg(4'd9, 32'h0000_FFFF);
    step(1,0,0,0);
    expect_reg("R9 carry into high half", 4'd9, 32'h0001_0000);
    step(0,0,0,0);
    expect_reg("R9 borrow from high half", 4'd9, 32'h0000_FFFF);
    wr_reg(4'd10, 32'h0001_0005);
    wr_reg(4'd9, 32'h0);
    step(0,1,0,0);
    expect_reg("R9 down wrap to long ceiling", 4'd9, 32'h0001_0005);
    expect_reg("R6 dir in cascade", 4'd7, 32'h00);
    step(0,0,0,0);
    expect_reg("R9 up wrap at long ceiling", 4'd9, 32'h0);
    wr_reg(4'd0, 32'h0);
    expect_busy("R10 lceil write busy", 4'd10, 1'b1, 32'h7);
    expect_reg("R9 high half on cnt1", 4'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_x4();
    t_ceiling();
    t_pd();
    t_x2b();
    t_unsupported();
    t_disabled();
    t_collide();
    t_pinsel();
    t_cascade();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule